// File: doc/BRIEF.md
# Threshold-Triggered DMA Burst Requester

This block stages network traffic in a 16-byte FIFO that sits between a byte-serial network port and a parallel DMA port. It watches the FIFO fill level against a programmable trigger. When the trigger is reached it raises a bus request. After the grant it moves exactly one burst, strobing an address increment on every beat, and then lets the request go.

A 2-bit trigger code selects the fill point. The code gives the same byte count in both transfer widths: 2, 4, 8 or 12 bytes, which is 1, 2, 4 or 6 words in word mode. In receive direction the network fills the FIFO and each burst drains a trigger's worth of data to memory. In transmit direction each burst fills the FIFO from memory with 16 bytes minus the trigger, and the network drains it. Word mode moves two bytes per beat, and a lane-order bit picks which half of the 16-bit bus carries the earlier byte. Configuration is sampled only while no request is outstanding.

Top module: `dma_burst_requester`

## Requirements
- R1: While reset is held and right after it: bus_req, addr_inc, ovf_flag, unf_flag and net_out_valid are 0 and dma_rdata is 0.
- R2: In receive direction (cfg_tx=0) with byte width, bus_req stays low while the FIFO holds fewer bytes than the trigger. The trigger for cfg_thr 0/1/2/3 is 2/4/8/12 bytes. bus_req goes high on the second clock edge after the push that reaches the trigger.
- R3: In word width (cfg_word=1) the trigger codes mean 1/2/4/6 words, the same byte counts as R2. Every beat reports addr_inc=2, so address bit 0 never changes.
- R4: In transmit direction (cfg_tx=1), bus_req goes high once the FIFO holds no more than the trigger byte count, that is, once it has room for 16 minus the trigger.
- R5: The first beat follows the clock edge that samples bus_grant high while bus_req is high. Beats then run on consecutive cycles. A burst is the trigger byte count in receive and 16 minus the trigger in transmit, in beats of 1 byte (addr_inc=1) or 2 bytes (addr_inc=2). addr_inc is 0 outside beats.
- R6: bus_req stays high from its rise until the last beat of the burst and is low in the cycle after it. It rises again only when the R2/R4 condition holds again.
- R7: Lane order, where the earlier byte is the one that came first from the network or goes first to it. With cfg_word=1 and cfg_swap=0 the earlier byte is on bits 7:0 and the later byte on 15:8. With cfg_swap=1 the lanes are swapped. With cfg_word=0 the byte uses bits 7:0, dma_rdata[15:8] is 0, dma_wdata[15:8] is unused, and cfg_swap has no effect.
- R8: Configuration inputs that change while bus_req is high do not affect the current burst. They take effect after it.
- R9: In receive direction, a byte pushed while the FIFO holds 16 bytes is dropped and sets ovf_flag, which stays set until reset.
- R10: In transmit direction, net_out_ready with an empty FIFO pops nothing and sets unf_flag, which stays set until reset.
- R11: Network inputs for the other direction are ignored. net_in_valid does nothing in transmit direction. net_out_ready does nothing in receive direction, and net_out_valid stays 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thr | input | 2 | Trigger code |
| cfg_word | input | 1 | 1 = 16-bit beats, 0 = byte beats |
| cfg_swap | input | 1 | Lane order in word mode |
| cfg_tx | input | 1 | 1 = transmit direction, 0 = receive |
| net_in_valid | input | 1 | Network byte present (receive) |
| net_in_data | input | 8 | Network byte (receive) |
| net_out_ready | input | 1 | Network takes a byte (transmit) |
| net_out_valid | output | 1 | A byte is available to the network |
| net_out_data | output | 8 | Byte to the network |
| bus_grant | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| addr_inc | output | 2 | Address step of the current beat (0 = no beat) |
| dma_rdata | output | 16 | Data toward memory during receive beats |
| dma_wdata | input | 16 | Data from memory during transmit beats |
| ovf_flag | output | 1 | Sticky receive overflow |
| unf_flag | output | 1 | Sticky transmit underflow |

## Verification
A wrong fill count surfaces at bus_req: the request rises one push early or late, and the bench checks it at the exact negative edge after the threshold push. A wrong beat counter or a wrong burst length shows at the negative edge right after the burst as a leftover addr_inc strobe or a request that does not drop. Wrong FIFO pointers or lane steering show in the data on the first beat that reads the damaged entry, and the overflow scenario reads past the dropped byte to prove it was never written.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

    localparam int FIFO_BYTES = 16;
    localparam int CNT_W      = $clog2(FIFO_BYTES + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [1:0] thr_code;
        logic       word;
        logic       swap;
        logic       tx;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } burst_st_e;

    // Receive trigger in bytes; the word-mode meaning is the same byte count.
    function automatic cnt_t rx_trigger(input logic [1:0] code);
        case (code)
            2'd0:    return cnt_t'(2);
            2'd1:    return cnt_t'(4);
            2'd2:    return cnt_t'(8);
            default: return cnt_t'(12);
        endcase
    endfunction

    function automatic cnt_t burst_bytes(input cfg_t c);
        return c.tx ? cnt_t'(FIFO_BYTES) - rx_trigger(c.thr_code)
                    : rx_trigger(c.thr_code);
    endfunction

    function automatic cnt_t burst_beats(input cfg_t c);
        return c.word ? (burst_bytes(c) >> 1) : burst_bytes(c);
    endfunction

endpackage

// File: rtl/dbr_byte_fifo.sv
module dbr_byte_fifo #(
    parameter int DEPTH = 16,            // power of two
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_d0,
    input  logic [7:0]    push_d1,
    input  logic [1:0]    pop_n,
    output logic [7:0]    head0,
    output logic [7:0]    head1,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr] <= push_d0;
        if (push_n == 2'd2) mem[wr_ptr + AW'(1)] <= push_d1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];

endmodule

// File: rtl/dbr_burst_ctrl.sv
module dbr_burst_ctrl
    import dma_burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  cnt_t fill,
    input  logic grant,
    output cfg_t cfg_q,
    output logic req,
    output logic beat
);
    burst_st_e state;
    cnt_t      beats_left;
    logic      trig;

    always_comb begin
        if (cfg_q.tx) trig = (fill <= rx_trigger(cfg_q.thr_code));
        else          trig = (fill >= rx_trigger(cfg_q.thr_code));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            beats_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    // a changed setting is loaded first, then evaluated
                    if (cfg_in != cfg_q) cfg_q <= cfg_in;
                    else if (trig)       state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (grant) begin
                        state      <= ST_BURST;
                        beats_left <= burst_beats(cfg_q);
                    end
                end
                ST_BURST: begin
                    beats_left <= beats_left - cnt_t'(1);
                    if (beats_left == cnt_t'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req  = (state != ST_IDLE);
    assign beat = (state == ST_BURST);

endmodule

// File: rtl/dma_burst_requester.sv
module dma_burst_requester
    import dma_burst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_thr,
    input  logic        cfg_word,
    input  logic        cfg_swap,
    input  logic        cfg_tx,
    input  logic        net_in_valid,
    input  logic [7:0]  net_in_data,
    input  logic        net_out_ready,
    output logic        net_out_valid,
    output logic [7:0]  net_out_data,
    input  logic        bus_grant,
    output logic        bus_req,
    output logic [1:0]  addr_inc,
    output logic [15:0] dma_rdata,
    input  logic [15:0] dma_wdata,
    output logic        ovf_flag,
    output logic        unf_flag
);
    cfg_t       cfg_in;
    cfg_t       cfg_q;
    cnt_t       fill_cnt;
    logic       beat;
    logic       full;
    logic       empty;
    logic       net_push_ok;
    logic       net_pop_ok;
    logic [1:0] step;
    logic [1:0] push_n;
    logic [1:0] pop_n;
    logic [7:0] push_d0;
    logic [7:0] push_d1;
    logic [7:0] head0;
    logic [7:0] head1;

    assign cfg_in = '{thr_code: cfg_thr, word: cfg_word, swap: cfg_swap, tx: cfg_tx};

    dbr_burst_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .fill   (fill_cnt),
        .grant  (bus_grant),
        .cfg_q  (cfg_q),
        .req    (bus_req),
        .beat   (beat)
    );

    dbr_byte_fifo #(.DEPTH(FIFO_BYTES), .CW(CNT_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push_n  (push_n),
        .push_d0 (push_d0),
        .push_d1 (push_d1),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1),
        .count   (fill_cnt)
    );

    assign full        = (fill_cnt == cnt_t'(FIFO_BYTES));
    assign empty       = (fill_cnt == '0);
    assign step        = cfg_q.word ? 2'd2 : 2'd1;
    assign net_push_ok = !cfg_q.tx && net_in_valid && !full;
    assign net_pop_ok  = cfg_q.tx && net_out_ready && !empty;

    // steering between the two sides of the byte store
    always_comb begin
        if (cfg_q.tx) begin
            push_n = beat ? step : 2'd0;
            pop_n  = {1'b0, net_pop_ok};
            if (cfg_q.word && cfg_q.swap) begin
                push_d0 = dma_wdata[15:8];
                push_d1 = dma_wdata[7:0];
            end else begin
                push_d0 = dma_wdata[7:0];
                push_d1 = dma_wdata[15:8];
            end
        end else begin
            push_n  = {1'b0, net_push_ok};
            pop_n   = beat ? step : 2'd0;
            push_d0 = net_in_data;
            push_d1 = 8'h00;
        end
    end

    always_comb begin
        if (!beat || cfg_q.tx)  dma_rdata = 16'h0000;
        else if (!cfg_q.word)   dma_rdata = {8'h00, head0};
        else if (cfg_q.swap)    dma_rdata = {head0, head1};
        else                    dma_rdata = {head1, head0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (!cfg_q.tx && net_in_valid && full)  ovf_flag <= 1'b1;
            if (cfg_q.tx && net_out_ready && empty) unf_flag <= 1'b1;
        end
    end

    assign addr_inc      = beat ? step : 2'd0;
    assign net_out_valid = cfg_q.tx && !empty;
    assign net_out_data  = cfg_q.tx ? head0 : 8'h00;

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker
    import dma_burst_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic [1:0] addr_inc,
    input logic       ovf_flag,
    input logic       unf_flag,
    input logic       net_out_valid,
    input cnt_t       fill_cnt,
    input cfg_t       cfg_q
);
    a_r6_req_drops_after_beat: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(addr_inc != 2'd0));

    a_r5_beat_under_req: assert property (@(posedge clk) disable iff (rst)
        (addr_inc != 2'd0) |-> bus_req);

    a_r3_step_legal: assert property (@(posedge clk) disable iff (rst)
        addr_inc != 2'd3);

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> $stable(cfg_q));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= cnt_t'(FIFO_BYTES));

    a_r11_rx_no_out: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.tx |-> !net_out_valid);
endmodule

bind dma_burst_requester dbr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .addr_inc      (addr_inc),
    .ovf_flag      (ovf_flag),
    .unf_flag      (unf_flag),
    .net_out_valid (net_out_valid),
    .fill_cnt      (fill_cnt),
    .cfg_q         (cfg_q)
);

// File: tb/dma_burst_requester_bench.sv
`timescale 1ns/1ps
module dma_burst_requester_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_thr = 2'd0;
    logic        cfg_word = 1'b0, cfg_swap = 1'b0, cfg_tx = 1'b0;
    logic        net_in_valid = 1'b0;
    logic [7:0]  net_in_data = 8'h00;
    logic        net_out_ready = 1'b0;
    logic        net_out_valid;
    logic [7:0]  net_out_data;
    logic        bus_grant = 1'b0;
    logic        bus_req;
    logic [1:0]  addr_inc;
    logic [15:0] dma_rdata;
    logic [15:0] dma_wdata = 16'h0000;
    logic        ovf_flag, unf_flag;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [15:0] got    [32];
    logic [15:0] supply [32];

    always #4 clk = ~clk;

    dma_burst_requester u_dma_burst_requester (
        .clk(clk), .rst(rst), .cfg_thr(cfg_thr), .cfg_word(cfg_word),
        .cfg_swap(cfg_swap), .cfg_tx(cfg_tx), .net_in_valid(net_in_valid),
        .net_in_data(net_in_data), .net_out_ready(net_out_ready),
        .net_out_valid(net_out_valid), .net_out_data(net_out_data),
        .bus_grant(bus_grant), .bus_req(bus_req), .addr_inc(addr_inc),
        .dma_rdata(dma_rdata), .dma_wdata(dma_wdata),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic int trig(input logic [1:0] c);
        case (c)
            2'd0: return 2;
            2'd1: return 4;
            2'd2: return 8;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] thr, input bit word, input bit swap, input bit tx);
        @(negedge clk);
        rst = 1'b1; bus_grant = 1'b0; net_in_valid = 1'b0; net_out_ready = 1'b0;
        cfg_thr = thr; cfg_word = word; cfg_swap = swap; cfg_tx = tx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic net_push(input logic [7:0] b);
        net_in_valid = 1'b1; net_in_data = b;
        @(negedge clk);
        net_in_valid = 1'b0;
    endtask

    task automatic net_pop(output logic [7:0] b);
        b = net_out_data;
        net_out_ready = 1'b1;
        @(negedge clk);
        net_out_ready = 1'b0;
    endtask

    task automatic wait_req();
        for (int w = 0; w < 20 && !bus_req; w++) @(negedge clk);
    endtask

    // grants, runs one burst, records read data and feeds write data per beat
    task automatic do_burst(input int n_beats, input logic [1:0] step, output int got_n);
        got_n = 0;
        bus_grant = 1'b1;
        for (int w = 0; w < 40 && got_n < n_beats; w++) begin
            @(negedge clk);
            if (addr_inc != 2'd0) begin
                chk("R5 beat step", addr_inc, step);
                got[got_n] = dma_rdata;
                dma_wdata  = supply[got_n];
                got_n++;
                bus_grant = 1'b0;
            end
        end
        @(negedge clk);
        chk("R5 no beat after burst", addr_inc, 2'd0);
        chk("R6 req low after last beat", bus_req, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; cfg_thr = 2'd0; cfg_word = 1'b0; cfg_swap = 1'b0; cfg_tx = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 req in reset", bus_req, 1'b0);
        chk("R1 addr_inc in reset", addr_inc, 2'd0);
        chk("R1 ovf in reset", ovf_flag, 1'b0);
        chk("R1 unf in reset", unf_flag, 1'b0);
        chk("R1 net_out_valid in reset", net_out_valid, 1'b0);
        chk("R1 dma_rdata in reset", dma_rdata, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req after reset", bus_req, 1'b0);
    endtask

    task automatic t_rx_byte();
        int g;
        for (int c = 0; c < 4; c++) begin
            int n = trig(2'(c));
            start(2'(c), 1'b0, c == 2, 1'b0);
            for (int i = 0; i < n - 1; i++) net_push(8'(c * 16 + i));
            repeat (3) @(negedge clk);
            chk("R2 req below trigger", bus_req, 1'b0);
            net_push(8'(c * 16 + n - 1));
            chk("R2 req not yet", bus_req, 1'b0);
            @(negedge clk);
            chk("R2 req at trigger", bus_req, 1'b1);
            do_burst(n, 2'd1, g);
            chk("R5 rx byte burst length", g, n);
            for (int i = 0; i < n; i++)
                chk("R7 byte lane, swap ignored", got[i], {8'h00, 8'(c * 16 + i)});
        end
    endtask

    task automatic t_rx_word();
        int g;
        start(2'd1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) net_push(8'hA0 + 8'(i));
        repeat (3) @(negedge clk);
        chk("R3 word trigger 2 words not met", bus_req, 1'b0);
        net_push(8'hA3);
        @(negedge clk);
        chk("R3 word trigger met", bus_req, 1'b1);
        do_burst(2, 2'd2, g);
        chk("R3 word beats", g, 2);
        chk("R7 swap0 beat0", got[0], 16'hA1A0);
        chk("R7 swap0 beat1", got[1], 16'hA3A2);

        start(2'd3, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 11; i++) net_push(8'hC0 + 8'(i));
        repeat (3) @(negedge clk);
        chk("R3 six-word trigger not met", bus_req, 1'b0);
        net_push(8'hCB);
        @(negedge clk);
        chk("R3 six-word trigger met", bus_req, 1'b1);
        do_burst(6, 2'd2, g);
        chk("R3 six beats", g, 6);
        for (int i = 0; i < 6; i++)
            chk("R7 swap1 lanes", got[i], {8'hC0 + 8'(2 * i), 8'hC1 + 8'(2 * i)});
    endtask

    task automatic t_tx();
        int g;
        logic [7:0] b;
        start(2'd0, 1'b0, 1'b1, 1'b1);
        wait_req();
        chk("R4 tx req on empty", bus_req, 1'b1);
        for (int i = 0; i < 14; i++) supply[i] = {8'hEE, 8'h60 + 8'(i)};
        do_burst(14, 2'd1, g);
        chk("R5 tx burst 16-2", g, 14);
        for (int i = 0; i < 11; i++) begin
            net_pop(b);
            chk("R7 tx byte order", b, 8'h60 + 8'(i));
        end
        @(negedge clk);
        chk("R4 tx req held off at 3 bytes", bus_req, 1'b0);
        net_pop(b);
        chk("R7 tx byte 11", b, 8'h6B);
        @(negedge clk);
        chk("R4 tx req at 2 bytes", bus_req, 1'b1);

        start(2'd2, 1'b1, 1'b1, 1'b1);
        wait_req();
        for (int i = 0; i < 4; i++) supply[i] = {8'h70 + 8'(2 * i), 8'h71 + 8'(2 * i)};
        do_burst(4, 2'd2, g);
        chk("R3 tx word beats", g, 4);
        for (int i = 0; i < 8; i++) begin
            net_pop(b);
            chk("R7 tx swap1 order", b, 8'h70 + 8'(i));
        end
    endtask

    task automatic t_rearm();
        int g;
        start(2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) net_push(8'h80 + 8'(i));
        wait_req();
        do_burst(2, 2'd1, g);
        chk("R6 first burst data", got[1], 16'h0081);
        @(negedge clk);
        chk("R6 re-request with 2 left", bus_req, 1'b1);
        do_burst(2, 2'd1, g);
        chk("R6 second burst data", got[0], 16'h0082);
        repeat (4) @(negedge clk);
        chk("R6 no re-request when empty", bus_req, 1'b0);
    endtask

    task automatic t_cfg_freeze();
        int g;
        start(2'd0, 1'b0, 1'b0, 1'b0);
        net_push(8'h11); net_push(8'h12);
        @(negedge clk);
        chk("R8 req up", bus_req, 1'b1);
        cfg_thr = 2'd3; cfg_word = 1'b1;
        do_burst(2, 2'd1, g);
        chk("R8 old setting used for burst", g, 2);
        for (int i = 0; i < 11; i++) net_push(8'h20 + 8'(i));
        repeat (3) @(negedge clk);
        chk("R8 new trigger applied after burst", bus_req, 1'b0);
        net_push(8'h2B);
        @(negedge clk);
        chk("R8 new trigger reached", bus_req, 1'b1);
    endtask

    task automatic t_overflow();
        int g;
        start(2'd3, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) net_push(8'h90 + 8'(i));
        chk("R9 no ovf at full", ovf_flag, 1'b0);
        net_push(8'hFF);
        chk("R9 ovf set", ovf_flag, 1'b1);
        do_burst(12, 2'd1, g);
        chk("R9 first burst head", got[0], 16'h0090);
        for (int i = 0; i < 8; i++) net_push(8'hA0 + 8'(i));
        @(negedge clk);
        do_burst(12, 2'd1, g);
        chk("R9 tail before new data", got[3], 16'h009F);
        chk("R9 dropped byte absent", got[4], 16'h00A0);
        chk("R9 ovf sticky", ovf_flag, 1'b1);
    endtask

    task automatic t_underflow();
        start(2'd0, 1'b0, 1'b0, 1'b1);
        chk("R10 unf clear", unf_flag, 1'b0);
        net_out_ready = 1'b1;
        @(negedge clk);
        net_out_ready = 1'b0;
        chk("R10 unf set", unf_flag, 1'b1);
        chk("R10 nothing available", net_out_valid, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 unf sticky", unf_flag, 1'b1);
    endtask

    task automatic t_wrong_dir();
        int g;
        logic [7:0] b;
        start(2'd0, 1'b0, 1'b0, 1'b0);
        net_out_ready = 1'b1;
        repeat (3) @(negedge clk);
        net_out_ready = 1'b0;
        chk("R11 rx pop ignored, no unf", unf_flag, 1'b0);
        chk("R11 rx no out valid", net_out_valid, 1'b0);

        start(2'd0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) net_push(8'h55);
        wait_req();
        for (int i = 0; i < 14; i++) supply[i] = {8'h00, 8'hB0 + 8'(i)};
        do_burst(14, 2'd1, g);
        for (int i = 0; i < 14; i++) begin
            net_pop(b);
            chk("R11 tx data unaffected by net_in", b, 8'hB0 + 8'(i));
        end
        chk("R11 exactly burst bytes held", net_out_valid, 1'b0);
        chk("R11 no ovf in tx", ovf_flag, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rx_byte();
        t_rx_word();
        t_tx();
        t_rearm();
        t_cfg_freeze();
        t_overflow();
        t_underflow();
        t_wrong_dir();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule